// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Merger

This block combines the interrupt requests of two IDE channels into one level-sensitive PCI interrupt line. Each channel has a pending flag and a block flag. The pending flag follows the channel's interrupt level. The block flag can only be set or cleared by software. The shared line is high while at least one channel is pending and not blocked.

Software reaches the block through a byte-wide port that is split into four offsets. A port select input chooses which channel's copy of the port is being used.

- Offset 1 is the shared mode byte. Both channel copies of the port see the same mode byte.
- Offset 3 holds a timing byte that belongs to each channel separately. The channel select picks which one is read or written.
- Offsets 0 and 2 belong to other logic and are not part of this block.

The block has no state machine. It is built from two identical channel slices, created with a generate loop. A registered output stage ORs the slices' requests together. The flags and the output register all load on the same clock edge.

Top module: `ide_irq_merge`

## Requirements
- R1: After reset, both pending flags, both block flags and both timing bytes are zero, and `irq_line` is low.
- R2: The mode byte holds the pending flag of channel 0 at bit 2 and of channel 1 at bit 3. Each pending flag takes the value of `lvl_in[0]` or `lvl_in[1]` sampled at each rising clock edge. A rising level sets the flag and a falling level clears it.
- R3: A write to offset 1 loads bit 4 (block channel 0) and bit 5 (block channel 1) from `bus_wdata`. It does not change the pending flags. Bits 0, 1, 6 and 7 always read as zero.
- R4: `irq_line` is high exactly when (pending0 AND NOT block0) OR (pending1 AND NOT block1).
- R5: `irq_line` is a register. It changes on the same clock edge that updates the flags, whether the cause is a level change or a mode write, and never between edges.
- R6: Offset 3 reads and writes the timing byte of the channel chosen by `bus_chan`. The other channel's timing byte is not affected.
- R7: The mode byte at offset 1 is shared. A write through either value of `bus_chan` is seen through both.
- R8: Reads at offset 0 or 2 return 0xFF. Writes at those offsets change neither the block flags nor the timing bytes.
- R9: A mode write and a level change in the same cycle both take effect on that one edge, and `irq_line` reflects both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_in | input | 2 | Interrupt level from each channel |
| bus_en | input | 1 | Port access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_chan | input | 1 | Channel copy of the port being accessed |
| bus_off | input | 2 | Byte offset within the port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from stored state |
| irq_line | output | 1 | Merged level interrupt |

## Verification
The assertions assume that `lvl_in` is held low while reset is active, and that the port inputs are stable around each rising edge. The bench meets both assumptions:

- It drives every input only on falling edges.
- It keeps the levels at zero until reset has been released.

Random traffic mixes level toggles with writes to all four offsets through both channel copies of the port. Directed cases cover the shared mode byte, the reserved offsets, and a block write that lands in the same cycle as a level change.

// File: rtl/ide_irq_merge_pkg.sv
package ide_irq_merge_pkg;
    localparam int NCH      = 2;
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int BYTE_W   = 8;
    localparam int OFF_W    = 2;
    localparam int PEND_LSB = 2;
    localparam int BLK_LSB  = 4;
    localparam logic [BYTE_W-1:0] IDLE_READ = '1;

    typedef enum logic [OFF_W-1:0] {
        OFF_RSV0   = 2'd0,
        OFF_MODE   = 2'd1,
        OFF_RSV2   = 2'd2,
        OFF_TIMING = 2'd3
    } port_off_e;
endpackage

// File: rtl/ide_irq_chan.sv
module ide_irq_chan #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic              blk_we,
    input  logic              blk_d,
    input  logic              tim_we,
    input  logic [BYTE_W-1:0] tim_d,
    output logic              pend,
    output logic              blk,
    output logic [BYTE_W-1:0] tim,
    output logic              req_nxt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            blk  <= 1'b0;
            tim  <= '0;
        end else begin
            pend <= lvl;
            if (blk_we) blk <= blk_d;
            if (tim_we) tim <= tim_d;
        end
    end

    // request this slice will present after the coming edge
    always_comb req_nxt = lvl & ~(blk_we ? blk_d : blk);

    a_r2_pend_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend == $past(lvl));
    a_r3_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_we |=> $stable(blk));
    a_r6_timing_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tim_we |=> $stable(tim));
endmodule

// File: rtl/ide_irq_merge.sv
module ide_irq_merge (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [ide_irq_merge_pkg::NCH-1:0]         lvl_in,
    input  logic                                      bus_en,
    input  logic                                      bus_we,
    input  logic [ide_irq_merge_pkg::CH_W-1:0]        bus_chan,
    input  logic [ide_irq_merge_pkg::OFF_W-1:0]       bus_off,
    input  logic [ide_irq_merge_pkg::BYTE_W-1:0]      bus_wdata,
    output logic [ide_irq_merge_pkg::BYTE_W-1:0]      bus_rdata,
    output logic                                      irq_line
);
    import ide_irq_merge_pkg::*;

    port_off_e         off;
    logic              mode_wr;
    logic [NCH-1:0]    pend_v, blk_v, req_nxt_v, tim_we_v;
    logic [BYTE_W-1:0] tim_arr [NCH];
    logic [BYTE_W-1:0] mode_byte;

    always_comb begin
        off     = port_off_e'(bus_off);
        mode_wr = bus_en && bus_we && (off == OFF_MODE);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        always_comb tim_we_v[i] = bus_en && bus_we && (off == OFF_TIMING)
                                  && (bus_chan == CH_W'(i));
        ide_irq_chan #(.BYTE_W(BYTE_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (lvl_in[i]),
            .blk_we  (mode_wr),
            .blk_d   (bus_wdata[BLK_LSB+i]),
            .tim_we  (tim_we_v[i]),
            .tim_d   (bus_wdata),
            .pend    (pend_v[i]),
            .blk     (blk_v[i]),
            .tim     (tim_arr[i]),
            .req_nxt (req_nxt_v[i])
        );
    end

    always_comb begin
        mode_byte                    = '0;
        mode_byte[PEND_LSB +: NCH]   = pend_v;
        mode_byte[BLK_LSB  +: NCH]   = blk_v;
    end

    // merged line loads with the flags on one edge
    always_ff @(posedge clk) begin
        if (!rst_n) irq_line <= 1'b0;
        else        irq_line <= |req_nxt_v;
    end

    always_comb begin
        unique case (off)
            OFF_MODE:   bus_rdata = mode_byte;
            OFF_TIMING: bus_rdata = tim_arr[bus_chan];
            default:    bus_rdata = IDLE_READ;
        endcase
    end

    a_r4_line_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line == |(pend_v & ~blk_v));
    a_r3_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte[1:0] == 2'b00) && (mode_byte[7:6] == 2'b00));
    a_r8_reserved_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && (off == OFF_RSV0 || off == OFF_RSV2))
        |=> ($stable(blk_v) && $stable(tim_arr[0]) && $stable(tim_arr[1])));
    a_r5_line_moves_with_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(irq_line) |-> ($changed(pend_v) || $changed(blk_v)));
endmodule

// File: tb/ide_irq_merge_test.sv
`timescale 1ns/1ps
module ide_irq_merge_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lvl_in = '0;
    logic       bus_en = 1'b0, bus_we = 1'b0, bus_chan = 1'b0;
    logic [1:0] bus_off = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_line;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_pend = '0, m_blk = '0;
    logic [7:0] m_tim [2] = '{8'h00, 8'h00};

    ide_irq_merge uut (
        .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .bus_en(bus_en),
        .bus_we(bus_we), .bus_chan(bus_chan), .bus_off(bus_off),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] exp_mode(logic [1:0] p, logic [1:0] b);
        return {2'b00, b, p, 2'b00};
    endfunction

    function automatic logic exp_irq(logic [1:0] p, logic [1:0] b);
        return |(p & ~b);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(logic ch, logic [1:0] off, string req, logic [7:0] exp);
        bus_en = 1'b1; bus_we = 1'b0; bus_chan = ch; bus_off = off;
        #0.2;
        chk(req, bus_rdata, exp);
        bus_en = 1'b0;
    endtask

    // drive one cycle at a falling edge, then update the model at the rising edge
    task automatic cyc(logic [1:0] lv, logic en, logic we, logic ch,
                       logic [1:0] off, logic [7:0] wd);
        lvl_in = lv; bus_en = en; bus_we = we; bus_chan = ch;
        bus_off = off; bus_wdata = wd;
        @(posedge clk);
        m_pend = lv;
        if (en && we && off == 2'd1) m_blk = wd[5:4];
        if (en && we && off == 2'd3) m_tim[ch] = wd;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic full_check(string tag);
        chk({tag, " R4 line"}, {7'd0, irq_line}, {7'd0, exp_irq(m_pend, m_blk)});
        rd(1'b0, 2'd1, {tag, " R2/R3 mode"}, exp_mode(m_pend, m_blk));
        rd(1'b0, 2'd3, {tag, " R6 tim0"}, m_tim[0]);
        rd(1'b1, 2'd3, {tag, " R6 tim1"}, m_tim[1]);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        full_check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        full_check("R1 after release");

        // R2 / R5: flag and line move on the edge, not before
        lvl_in = 2'b01; #0.2;
        chk("R5 line before edge", {7'd0, irq_line}, 8'd0);
        cyc(2'b01, 0, 0, 0, 2'd0, 8'h00);
        full_check("R2 ch0 rise");
        cyc(2'b10, 0, 0, 0, 2'd0, 8'h00);
        full_check("R2 ch1 swap");

        // R3: write tries to set pending and spare bits; only blocks load
        cyc(2'b10, 1, 1, 0, 2'd1, 8'hEF);
        full_check("R3 masked write");
        chk("R3 line blocked", {7'd0, irq_line}, 8'd0);

        // R7: write through channel 1 copy, read through channel 0 copy
        cyc(2'b11, 1, 1, 1, 2'd1, 8'h10);
        rd(1'b0, 2'd1, "R7 shared via ch0", 8'h1C);
        rd(1'b1, 2'd1, "R7 shared via ch1", 8'h1C);
        chk("R4 ch1 unblocked", {7'd0, irq_line}, 8'd1);

        // R6: per-channel timing bytes
        cyc(2'b11, 1, 1, 0, 2'd3, 8'hA5);
        cyc(2'b11, 1, 1, 1, 2'd3, 8'h3C);
        full_check("R6 timing");

        // R8: reserved offsets
        rd(1'b0, 2'd0, "R8 read off0", 8'hFF);
        rd(1'b1, 2'd2, "R8 read off2", 8'hFF);
        cyc(2'b11, 1, 1, 0, 2'd0, 8'h00);
        cyc(2'b11, 1, 1, 1, 2'd2, 8'hFF);
        full_check("R8 reserved writes");

        // R9: block write and level change on one edge
        cyc(2'b11, 1, 1, 0, 2'd1, 8'h30);
        chk("R4 all blocked", {7'd0, irq_line}, 8'd0);
        lvl_in = 2'b01; #0.2;
        chk("R5 no change between edges", {7'd0, irq_line}, 8'd0);
        cyc(2'b01, 1, 1, 0, 2'd1, 8'h20);
        full_check("R9 same edge");
        chk("R9 line", {7'd0, irq_line}, 8'd1);

        for (int n = 0; n < 600; n++) begin
            logic [1:0] lv;
            logic [7:0] wd;
            logic [1:0] off;
            logic ch, en;
            lv  = 2'($urandom);
            wd  = 8'($urandom);
            off = 2'($urandom);
            ch  = 1'($urandom);
            en  = ($urandom % 3) != 0;
            cyc(lv, en, 1'b1, ch, off, wd);
            full_check("rand");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule